// File: doc/BRIEF.md
# Fixed-Point Time-of-Day Counter with Atomic Adjust

This block keeps the time of day for a precision timing subsystem. On every reference clock cycle it adds a programmable increment to a fractional nanosecond accumulator. The increment is a 32.32 fixed-point count of nanoseconds per cycle, nominally (10^9 * 2^32) divided by the reference frequency. The time has three fields: a 32-bit fractional part, a 32-bit nanosecond field, and a 32-bit seconds counter. The nanosecond field wraps when it reaches the active upper rollover point. On a wrap the span between the two rollover points is subtracted and the excess is kept, and the seconds counter steps up by one.

Software writes staged values through a simple write port: nanoseconds, fraction, seconds, and a lower and an upper rollover point. It then writes an operation code into the configuration word. The code applies the staged values on a single cycle. Set loads them all. Increment and decrement shift the running time by the staged nanosecond count, which is meant for corrections below one second. A decrement that goes below the lower rollover point borrows a second, and at zero seconds the time clamps to zero.

An external event input passes through a synchroniser. A chosen edge of it latches the current seconds and nanoseconds into a capture register.

Top module: `tod_counter`

## Requirements
- R1: After reset the time fields, the configuration word (address 0), the capture strobe and the capture stamp are zero. The increment is 5 ns (0x0000_0005_0000_0000), the lower rollover point is 0 and the upper one is 1,000,000,000.
- R2: When configuration bit 0 is low and no operation is pending, the seconds, nanosecond and fraction outputs hold their values.
- R3: When configuration bit 0 is high, each clock edge adds the 64-bit increment to {nanoseconds, fraction}. The increment is written at address 1, with nanoseconds in bits 63:32 and fraction in bits 31:0.
- R4: When the nanosecond field reaches or passes the upper rollover point, it drops by (upper - lower) and keeps the excess, the fraction is kept, and the seconds count rises by one.
- R5: The operation field sits at configuration bits 28:26. A written code is visible for exactly one cycle. It takes effect on the next edge, which also clears the field to zero.
- R6: Code 1 (set) loads the staged nanoseconds (address 2), fraction (address 3), seconds (address 4), lower rollover point (address 5) and upper rollover point (address 6), with no increment added on that cycle.
- R7: Code 3 (increment) produces the time plus that cycle's increment plus the staged nanoseconds, carrying into seconds as in R4.
- R8: Code 4 (decrement) produces the time plus that cycle's increment minus the staged nanoseconds. A result below the lower rollover point gains (upper - lower) and takes one second.
- R9: A decrement that would borrow while seconds is zero leaves seconds at zero, nanoseconds at the lower rollover point and fraction at zero.
- R10: Any other non-zero operation code changes nothing beyond normal counting and still clears itself.
- R11: A new increment written while counting is first used on the edge after the write edge.
- R12: With configuration bit 8 high, an edge of the event input latches {seconds, nanoseconds} into the stamp (seconds in bits 63:32, nanoseconds in bits 31:0) and pulses the strobe for one cycle. Bit 9 low selects the rising edge and bit 9 high the falling edge. The stamp holds the time seen two edges after the input changes and appears one edge later.
- R13: With bit 8 low, or on the edge that is not selected, the strobe stays low and the stamp keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| ext_evt | input | 1 | Asynchronous external event for capture |
| cfg_word | output | 32 | Current configuration word |
| tod_sec | output | 32 | Seconds count |
| tod_ns | output | 32 | Nanosecond field |
| tod_frac | output | 32 | Fractional nanoseconds |
| cap_strobe | output | 1 | One-cycle pulse when a stamp is taken |
| cap_stamp | output | 64 | Captured seconds and nanoseconds |

## Verification
A register write takes one edge. An operation code is visible for one cycle after the configuration write, and its result appears after the following edge. Each count step is due one edge after the state it builds on. A capture is stamped with the time seen two edges after the event pin changes, and it appears one edge after that. Every result is known to the cycle. The bench drives and samples only on falling clock edges and advances one rising edge per step, so each expected value is worked out from the edge count. Counting sweeps compare every cycle against a closed-form sum of the start time and n increments.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned NS_W   = 32;
  localparam int unsigned FRAC_W = 32;
  localparam int unsigned SEC_W  = 32;
  localparam int unsigned INCR_W = NS_W + FRAC_W;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BUS_W  = 64;
  localparam int unsigned STAMP_W = SEC_W + NS_W;

  localparam int unsigned CFG_RUN_BIT   = 0;
  localparam int unsigned CFG_CAP_BIT   = 8;
  localparam int unsigned CFG_FALL_BIT  = 9;
  localparam int unsigned CFG_OP_LSB    = 26;
  localparam int unsigned CFG_OP_W      = 3;

  typedef enum logic [CFG_OP_W-1:0] {
    OP_NONE = 3'd0,
    OP_SET  = 3'd1,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4
  } tod_op_e;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CFG      = 3'd0,
    ADDR_INCR     = 3'd1,
    ADDR_STG_NS   = 3'd2,
    ADDR_STG_FRAC = 3'd3,
    ADDR_STG_SEC  = 3'd4,
    ADDR_ROLL_LO  = 3'd5,
    ADDR_ROLL_HI  = 3'd6
  } tod_addr_e;

  typedef struct packed {
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   roll_lo;
    logic [NS_W-1:0]   roll_hi;
  } tod_stage_t;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter logic [NS_W-1:0]   NS_PER_SEC = 32'd1_000_000_000,
  parameter logic [INCR_W-1:0] INCR_RESET = 64'h0000_0005_0000_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BUS_W-1:0]        wr_data,
  output logic [CFG_W-1:0]        cfg_q,
  output logic [INCR_W-1:0]       incr_q,
  output tod_stage_t              stage_q,
  output logic [CFG_OP_W-1:0]     op_code,
  output logic                    run_en,
  output logic                    cap_en,
  output logic                    cap_fall
);
  logic             cfg_we, incr_we, ns_we, frac_we, sec_we, lo_we, hi_we;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_we  = wr_en && (wr_addr == ADDR_CFG);
    incr_we = wr_en && (wr_addr == ADDR_INCR);
    ns_we   = wr_en && (wr_addr == ADDR_STG_NS);
    frac_we = wr_en && (wr_addr == ADDR_STG_FRAC);
    sec_we  = wr_en && (wr_addr == ADDR_STG_SEC);
    lo_we   = wr_en && (wr_addr == ADDR_ROLL_LO);
    hi_we   = wr_en && (wr_addr == ADDR_ROLL_HI);
    cfg_d = cfg_q;
    cfg_d[CFG_OP_LSB +: CFG_OP_W] = '0;
    if (cfg_we) cfg_d = wr_data[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q           <= '0;
      incr_q          <= INCR_RESET;
      stage_q.ns      <= '0;
      stage_q.frac    <= '0;
      stage_q.sec     <= '0;
      stage_q.roll_lo <= '0;
      stage_q.roll_hi <= NS_PER_SEC;
    end else begin
      cfg_q <= cfg_d;
      if (incr_we) incr_q          <= wr_data[INCR_W-1:0];
      if (ns_we)   stage_q.ns      <= wr_data[NS_W-1:0];
      if (frac_we) stage_q.frac    <= wr_data[FRAC_W-1:0];
      if (sec_we)  stage_q.sec     <= wr_data[SEC_W-1:0];
      if (lo_we)   stage_q.roll_lo <= wr_data[NS_W-1:0];
      if (hi_we)   stage_q.roll_hi <= wr_data[NS_W-1:0];
    end
  end

  assign op_code  = cfg_q[CFG_OP_LSB +: CFG_OP_W];
  assign run_en   = cfg_q[CFG_RUN_BIT];
  assign cap_en   = cfg_q[CFG_CAP_BIT];
  assign cap_fall = cfg_q[CFG_FALL_BIT];

  // R5: an operation code lives for one cycle only
  a_r5_op_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code != OP_NONE && !cfg_we) |=> (op_code == OP_NONE));

  // R11: a new increment is held from the edge that wrote it
  a_r11_incr_written: assert property (@(posedge clk) disable iff (!rst_n)
    incr_we |=> (incr_q == $past(wr_data)));
endmodule

// File: rtl/tod_core.sv
module tod_core
  import tod_pkg::*;
#(
  parameter logic [NS_W-1:0] NS_PER_SEC = 32'd1_000_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic [CFG_OP_W-1:0] op_code,
  input  logic [INCR_W-1:0]   incr,
  input  tod_stage_t          stage,
  output logic [NS_W-1:0]     ns_q,
  output logic [FRAC_W-1:0]   frac_q,
  output logic [SEC_W-1:0]    sec_q
);
  localparam int unsigned XW = NS_W + 3;
  localparam logic [SEC_W-1:0] SEC_ONE = 1;

  logic [NS_W-1:0]          roll_lo_q, roll_hi_q;
  logic [INCR_W:0]          acc_sum;
  logic signed [XW-1:0]     base_s, stg_s, lo_s, hi_s, span_s, adj_s;
  logic                     over, under, sat, tick;
  logic [NS_W-1:0]          ns_d, lo_d, hi_d;
  logic [FRAC_W-1:0]        frac_d;
  logic [SEC_W-1:0]         sec_d;

  always_comb begin
    acc_sum = {1'b0, ns_q, frac_q} + (run_en ? {1'b0, incr} : '0);
    base_s  = signed'({2'b00, acc_sum[INCR_W:FRAC_W]});
    stg_s   = signed'({3'b000, stage.ns});
    lo_s    = signed'({3'b000, roll_lo_q});
    hi_s    = signed'({3'b000, roll_hi_q});
    span_s  = hi_s - lo_s;
    case (op_code)
      OP_INC:  adj_s = base_s + stg_s;
      OP_DEC:  adj_s = base_s - stg_s;
      default: adj_s = base_s;
    endcase
    over  = (adj_s >= hi_s);
    under = (op_code == OP_DEC) && (adj_s < lo_s);
    sat   = 1'b0;
    ns_d   = NS_W'(adj_s);
    frac_d = acc_sum[FRAC_W-1:0];
    sec_d  = sec_q;
    lo_d   = roll_lo_q;
    hi_d   = roll_hi_q;
    if (over) begin
      ns_d  = NS_W'(adj_s - span_s);
      sec_d = sec_q + SEC_ONE;
    end else if (under) begin
      if (sec_q == '0) begin
        sat    = 1'b1;
        ns_d   = roll_lo_q;
        frac_d = '0;
      end else begin
        ns_d  = NS_W'(adj_s + span_s);
        sec_d = sec_q - SEC_ONE;
      end
    end
    if (op_code == OP_SET) begin
      ns_d   = stage.ns;
      frac_d = stage.frac;
      sec_d  = stage.sec;
      lo_d   = stage.roll_lo;
      hi_d   = stage.roll_hi;
    end
    tick = run_en || (op_code != OP_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q      <= '0;
      frac_q    <= '0;
      sec_q     <= '0;
      roll_lo_q <= '0;
      roll_hi_q <= NS_PER_SEC;
    end else if (tick) begin
      ns_q      <= ns_d;
      frac_q    <= frac_d;
      sec_q     <= sec_d;
      roll_lo_q <= lo_d;
      roll_hi_q <= hi_d;
    end
  end

  // R2: idle counter keeps its time
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && op_code == OP_NONE) |=> ($stable(ns_q) && $stable(frac_q) && $stable(sec_q)));

  // R4: plain counting moves seconds only by one, and only with a nanosecond wrap
  a_r4_second_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && op_code == OP_NONE) |=>
      ((sec_q == $past(sec_q)) || ((sec_q == $past(sec_q) + SEC_ONE) && (ns_q < $past(ns_q)))));

  // R6: set lands the staged seconds and nanoseconds
  a_r6_set_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_SET) |=> ((ns_q == $past(stage.ns)) && (sec_q == $past(stage.sec))));

  // R9: a borrow at zero seconds clamps to time zero
  a_r9_dec_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    sat |=> ((sec_q == '0) && (frac_q == '0)));
endmodule

// File: rtl/tod_capture.sv
module tod_capture
  import tod_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_evt,
  input  logic               cap_en,
  input  logic               cap_fall,
  input  logic [SEC_W-1:0]   sec,
  input  logic [NS_W-1:0]    ns,
  output logic               strobe_q,
  output logic [STAMP_W-1:0] stamp_q
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, level, hit;
  logic [STAMP_W-1:0]     stamp_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = ext_evt;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], ext_evt};
    end
  endgenerate

  always_comb begin
    level   = sync_q[SYNC_STAGES-1];
    hit     = cap_en && (cap_fall ? (prev_q && !level) : (!prev_q && level));
    stamp_d = hit ? {sec, ns} : stamp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      strobe_q <= 1'b0;
      stamp_q  <= '0;
    end else begin
      sync_q   <= sync_d;
      prev_q   <= level;
      strobe_q <= hit;
      stamp_q  <= stamp_d;
    end
  end

  // R13: no strobe unless capture was enabled on the previous cycle
  a_r13_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> $past(cap_en));

  // R12: the stamp only moves together with a strobe
  a_r12_stamp_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_q |-> $stable(stamp_q));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter logic [NS_W-1:0]   NS_PER_SEC  = 32'd1_000_000_000,
  parameter logic [INCR_W-1:0] INCR_RESET  = 64'h0000_0005_0000_0000,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [63:0]   wr_data,
  input  logic          ext_evt,
  output logic [31:0]   cfg_word,
  output logic [31:0]   tod_sec,
  output logic [31:0]   tod_ns,
  output logic [31:0]   tod_frac,
  output logic          cap_strobe,
  output logic [63:0]   cap_stamp
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [INCR_W-1:0]   incr;
  tod_stage_t          stage;
  logic [CFG_OP_W-1:0] op_code;
  logic                run_en, cap_en, cap_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tod_regs #(.NS_PER_SEC(NS_PER_SEC), .INCR_RESET(INCR_RESET)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_q(cfg_word), .incr_q(incr), .stage_q(stage), .op_code(op_code),
    .run_en(run_en), .cap_en(cap_en), .cap_fall(cap_fall)
  );

  tod_core #(.NS_PER_SEC(NS_PER_SEC)) u_core (
    .clk(clk), .rst_n(rst_int_n), .run_en(run_en), .op_code(op_code), .incr(incr),
    .stage(stage), .ns_q(tod_ns), .frac_q(tod_frac), .sec_q(tod_sec)
  );

  tod_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .ext_evt(ext_evt), .cap_en(cap_en), .cap_fall(cap_fall),
    .sec(tod_sec), .ns(tod_ns), .strobe_q(cap_strobe), .stamp_q(cap_stamp)
  );
endmodule

// File: tb/tod_counter_test.sv
`timescale 1ns/1ps
module tod_counter_test;
  localparam longint unsigned NSEC = 64'd1_000_000_000;
  localparam logic [63:0] RUN = 64'h1, CAPR = 64'h101, CAPF = 64'h301;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, ext_evt;
  logic [2:0]  wr_addr;
  logic [63:0] wr_data;
  logic [31:0] cfg_word, tod_sec, tod_ns, tod_frac;
  logic        cap_strobe;
  logic [63:0] cap_stamp;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  tod_counter uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_evt(ext_evt), .cfg_word(cfg_word), .tod_sec(tod_sec),
    .tod_ns(tod_ns), .tod_frac(tod_frac), .cap_strobe(cap_strobe), .cap_stamp(cap_stamp));

  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] now();
    return {tod_sec, tod_ns, tod_frac};
  endfunction

  function automatic logic [95:0] tv(input logic [31:0] s, input logic [31:0] n, input logic [31:0] f);
    return {s, n, f};
  endfunction

  function automatic logic [95:0] after_n(input logic [31:0] s0, input logic [31:0] n0,
      input logic [31:0] f0, input logic [63:0] inc, input int n);
    longint unsigned tot, tns;
    tot = ({32'd0, n0} << 32) + {32'd0, f0} + longint'(n) * inc;
    tns = tot >> 32;
    return {s0 + 32'(tns / NSEC), 32'(tns % NSEC), tot[31:0]};
  endfunction

  task automatic set_time(input logic [31:0] s, input logic [31:0] n, input logic [31:0] f,
      input logic [31:0] lo, input logic [31:0] hi, input logic [63:0] flags);
    wr(3'd2, {32'd0, n}); wr(3'd3, {32'd0, f}); wr(3'd4, {32'd0, s});
    wr(3'd5, {32'd0, lo}); wr(3'd6, {32'd0, hi});
    wr(3'd0, flags | (64'd1 << 26));
    chk("R5 set code visible", {93'd0, cfg_word[28:26]}, 96'd1);
    step();
    chk("R6 set loads staged time", now(), tv(s, n, f));
    chk("R5 set code cleared", {93'd0, cfg_word[28:26]}, 96'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] incs [4];
    logic [95:0] snap;
    incs = '{64'h0000_0005_0000_0000, 64'h0000_0007_4000_0000,
             64'h0000_0000_C000_0000, 64'h0000_03E7_FFFF_FFFF};
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ext_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk("R1 time zero", now(), 96'd0);
    chk("R1 cfg zero", {64'd0, cfg_word}, 96'd0);
    chk("R1 capture idle", {31'd0, cap_strobe, cap_stamp}, 96'd0);
    // R2 stopped
    repeat (4) step();
    chk("R2 stopped time holds", now(), 96'd0);
    // R1 default increment of 5 ns
    wr(3'd0, RUN);
    chk("R1 run write edge", now(), 96'd0);
    step(); chk("R1 default incr", now(), tv(0, 5, 0));
    step(); chk("R1 default incr again", now(), tv(0, 10, 0));
    wr(3'd0, 64'd0);
    chk("R2 last count edge", now(), tv(0, 15, 0));
    repeat (3) step();
    chk("R2 hold after stop", now(), tv(0, 15, 0));

    // R3 R4 sweeps over several increments
    foreach (incs[k]) begin
      wr(3'd1, incs[k]);
      set_time(32'd2, 32'd999_999_000, 32'h1234_5678, 32'd0, 32'd1_000_000_000, RUN);
      for (int n = 1; n <= 200; n++) begin
        step();
        chk("R3 R4 sweep", now(), after_n(32'd2, 32'd999_999_000, 32'h1234_5678, incs[k], n));
      end
    end

    // R11 increment rewrite while running
    wr(3'd1, 64'h0000_0005_0000_0000);
    set_time(32'd1, 32'd1000, 32'd0, 32'd0, 32'd1_000_000_000, RUN);
    wr(3'd1, 64'h0000_0003_8000_0000);
    chk("R11 old incr on write edge", now(), tv(1, 1005, 0));
    step(); chk("R11 new incr next edge", now(), tv(1, 1008, 32'h8000_0000));
    step(); chk("R11 new incr steady", now(), tv(1, 1012, 0));

    // R7 increment op with carry into seconds
    set_time(32'd3, 32'd999_999_900, 32'd0, 32'd0, 32'd1_000_000_000, RUN);
    wr(3'd2, 64'd200);
    wr(3'd0, RUN | (64'd3 << 26));
    chk("R7 pre-apply", now(), tv(3, 999_999_907, 0));
    chk("R5 inc code visible", {93'd0, cfg_word[28:26]}, 96'd3);
    step(); chk("R7 inc applied with carry", now(), tv(4, 110, 32'h8000_0000));
    chk("R5 inc code cleared", {93'd0, cfg_word[28:26]}, 96'd0);
    step(); chk("R5 inc applied once", now(), tv(4, 114, 0));

    // R8 decrement op with borrow
    wr(3'd2, 64'd500);
    wr(3'd0, RUN | (64'd4 << 26));
    chk("R8 pre-apply", now(), tv(4, 121, 0));
    step(); chk("R8 dec borrow", now(), tv(3, 999_999_624, 32'h8000_0000));

    // R9 decrement saturation at zero seconds
    set_time(32'd0, 32'd100, 32'h4000_0000, 32'd0, 32'd1_000_000_000, RUN);
    wr(3'd2, 64'd500);
    wr(3'd0, RUN | (64'd4 << 26));
    chk("R9 pre-apply", now(), tv(0, 107, 32'h4000_0000));
    step(); chk("R9 clamp to zero", now(), 96'd0);
    step(); chk("R9 counts on after clamp", now(), tv(0, 3, 32'h8000_0000));

    // R10 undefined codes
    wr(3'd0, RUN | (64'd2 << 26));
    chk("R10 code 2 visible", {93'd0, cfg_word[28:26]}, 96'd2);
    step(); chk("R10 code 2 no effect", now(), tv(0, 10, 32'h8000_0000));
    chk("R10 code 2 cleared", {93'd0, cfg_word[28:26]}, 96'd0);
    wr(3'd0, RUN | (64'd7 << 26));
    step(); chk("R10 code 7 no effect", now(), tv(0, 17, 32'h8000_0000));

    // R4 R6 non-default rollover window
    wr(3'd1, 64'h0000_0005_0000_0000);
    set_time(32'd5, 32'd1_999_999_990, 32'd0, 32'd1_000_000_000, 32'd2_000_000_000, RUN);
    step(); chk("R4 window below", now(), tv(5, 1_999_999_995, 0));
    step(); chk("R4 window wrap", now(), tv(6, 1_000_000_000, 0));
    set_time(32'd0, 32'd0, 32'd0, 32'd0, 32'd1_000_000_000, RUN);

    // R12 rising capture
    wr(3'd0, CAPR);
    ext_evt = 1'b1;
    step(); step();
    snap = now();
    chk("R12 no strobe yet", {95'd0, cap_strobe}, 96'd0);
    step();
    chk("R12 rising strobe", {95'd0, cap_strobe}, 96'd1);
    chk("R12 rising stamp", {32'd0, cap_stamp}, {32'd0, snap[95:32]});
    step(); chk("R12 strobe one cycle", {95'd0, cap_strobe}, 96'd0);

    // R12 falling capture
    wr(3'd0, CAPF);
    ext_evt = 1'b0;
    step(); step();
    snap = now();
    step();
    chk("R12 falling strobe", {95'd0, cap_strobe}, 96'd1);
    chk("R12 falling stamp", {32'd0, cap_stamp}, {32'd0, snap[95:32]});

    // R13 unselected edge and disabled capture
    ext_evt = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(); chk("R13 rising ignored in falling mode", {95'd0, cap_strobe}, 96'd0);
    end
    chk("R13 stamp kept", {32'd0, cap_stamp}, {32'd0, snap[95:32]});
    wr(3'd0, RUN);
    ext_evt = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step(); chk("R13 disabled falling", {95'd0, cap_strobe}, 96'd0);
    end
    ext_evt = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(); chk("R13 disabled rising", {95'd0, cap_strobe}, 96'd0);
    end
    chk("R13 stamp kept when disabled", {32'd0, cap_stamp}, {32'd0, snap[95:32]});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule